// File: doc/BRIEF.md
# Test Access Port Protocol Monitor

This block watches a four-wire test access port without driving any of its lines. It is clocked by the port's own test clock. It rebuilds the port's sixteen-state controller from the mode-select stream alone, and it reports which state the controller is in, how long it has stayed there, and whether the scan in progress targets the instruction register or a data register. Each entry into a capture state, into an update state or into the reset state raises a one-cycle flag.

A scan runs from capture to update. During a scan the monitor counts the bits shifted and the cycles spent paused. It also collects the first bits seen on the serial input and the serial output into two words. When the controller reaches an update state, the monitor presents a report that holds the register type, the bit count, the pause count and both words, qualified by a one-cycle valid strobe. A debug or trace subsystem can log these reports to measure scan lengths and phase durations. It does not need to decode instructions for this.

Top module: `tap_watch`

## Requirements
- R1: While `rst_n` or `trst_n` is low at a rising edge of `tck`, the tracked state becomes test-logic-reset (code 0). While it is in that state, `tms` = 1 keeps it there and `tms` = 0 moves it to run-test/idle. `rst_n` also clears every report output, every flag and `scan_is_ir`.
- R2: `state` follows the controller on each rising edge of `tck`. The encoding is: 0 reset, 1 idle, 2 DR-select, 3 DR-capture, 4 DR-shift, 5 DR-exit1, 6 DR-pause, 7 DR-exit2, 8 DR-update, 9 IR-select, 10 IR-capture, 11 IR-shift, 12 IR-exit1, 13 IR-pause, 14 IR-exit2, 15 IR-update. The transitions are as follows. Idle goes to DR-select on 1. DR-select goes to IR-select on 1 and to DR-capture on 0. IR-select goes to reset on 1 and to IR-capture on 0. Capture and shift go to exit1 on 1 and to shift on 0. Exit1 goes to update on 1 and to pause on 0. Pause goes to exit2 on 1. Exit2 goes to update on 1 and to shift on 0. Update goes to DR-select on 1 and to idle on 0.
- R3: Five consecutive rising edges with `tms` = 1 always leave the state at reset.
- R4: `capture_pulse` is high for exactly the cycles in which the state is a capture state. `scan_is_ir` becomes 1 on entry to IR-capture and 0 on entry to DR-capture, and otherwise keeps its value.
- R5: Each rising edge taken while the state is a shift state samples `tdi` and `tdo`. The k-th bit of a scan (k from 0) goes to bit k of the collected words, so the words are LSB first. The same edge adds one to the bit count. Entering a capture state clears the counts and both words.
- R6: Each rising edge taken in a pause state adds one to the pause count and moves no data. Resuming shift from exit2 does not clear the count or the words.
- R7: The words keep only the first `WORD_W` bits of a scan, and later bits are ignored. The bit count and the pause count stop at their all-ones values.
- R8: `rpt_valid` and `update_pulse` are high for exactly the cycles in an update state. `rpt_is_ir`, `rpt_bits`, `rpt_pauses`, `rpt_tdi` and `rpt_tdo` then hold that scan's register type and totals.
- R9: `reset_pulse` is high for one cycle after each edge that takes the state into reset from any other state, whether by `tms` or by `trst_n`.
- R10: `dwell` is 0 in the first cycle of a state. It rises by one on each edge that keeps the state the same, and it stops at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; the monitor advances on its rising edge |
| rst_n | input | 1 | Synchronous active-low monitor reset |
| trst_n | input | 1 | Observed active-low test reset of the port |
| tms | input | 1 | Observed mode select |
| tdi | input | 1 | Observed serial data into the device |
| tdo | input | 1 | Observed serial data out of the device (driven on falling edges) |
| state | output | 4 | Tracked controller state, encoded as in R2 |
| dwell | output | DWELL_W | Cycles spent in the current state, saturating |
| scan_is_ir | output | 1 | 1 while the latest scan targets the instruction register |
| capture_pulse | output | 1 | High in a capture state |
| update_pulse | output | 1 | High in an update state |
| reset_pulse | output | 1 | High in the first cycle after entering reset |
| rpt_valid | output | 1 | Scan report valid strobe |
| rpt_is_ir | output | 1 | Reported scan targeted the instruction register |
| rpt_bits | output | CNT_W | Bits shifted in the reported scan |
| rpt_pauses | output | PAUSE_W | Pause cycles in the reported scan |
| rpt_tdi | output | WORD_W | Collected input word, LSB first |
| rpt_tdo | output | WORD_W | Collected output word, LSB first |

## Verification
The assertions assume that `rst_n` is held low for at least one rising edge before anything is observed. They also assume that `tms`, `tdi`, `tdo` and `trst_n` are stable around each rising edge of `tck`, because the monitor samples all of them on that edge. The bench drives every input only on falling edges and starts with several reset cycles. It then applies directed scans (with and without pauses, over-length, aborted by five highs, cut by the test reset) and a long stretch of random mode-select, data and occasional test-reset values. All of these remain legal streams for the port.

// File: rtl/tap_watch_pkg.sv
// Shared state encoding and transition function of the tracked test access
// port controller. Assumes one transition per rising test-clock edge.
package tap_watch_pkg;

    typedef enum logic [3:0] {
        TS_RESET    = 4'd0,
        TS_IDLE     = 4'd1,
        TS_DR_SEL   = 4'd2,
        TS_DR_CAP   = 4'd3,
        TS_DR_SHIFT = 4'd4,
        TS_DR_EXIT1 = 4'd5,
        TS_DR_PAUSE = 4'd6,
        TS_DR_EXIT2 = 4'd7,
        TS_DR_UPD   = 4'd8,
        TS_IR_SEL   = 4'd9,
        TS_IR_CAP   = 4'd10,
        TS_IR_SHIFT = 4'd11,
        TS_IR_EXIT1 = 4'd12,
        TS_IR_PAUSE = 4'd13,
        TS_IR_EXIT2 = 4'd14,
        TS_IR_UPD   = 4'd15
    } tap_state_e;

    // Successor of a state for one sampled mode-select bit.
    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        case (s)
            TS_RESET:    return m ? TS_RESET    : TS_IDLE;
            TS_IDLE:     return m ? TS_DR_SEL   : TS_IDLE;
            TS_DR_SEL:   return m ? TS_IR_SEL   : TS_DR_CAP;
            TS_DR_CAP:   return m ? TS_DR_EXIT1 : TS_DR_SHIFT;
            TS_DR_SHIFT: return m ? TS_DR_EXIT1 : TS_DR_SHIFT;
            TS_DR_EXIT1: return m ? TS_DR_UPD   : TS_DR_PAUSE;
            TS_DR_PAUSE: return m ? TS_DR_EXIT2 : TS_DR_PAUSE;
            TS_DR_EXIT2: return m ? TS_DR_UPD   : TS_DR_SHIFT;
            TS_DR_UPD:   return m ? TS_DR_SEL   : TS_IDLE;
            TS_IR_SEL:   return m ? TS_RESET    : TS_IR_CAP;
            TS_IR_CAP:   return m ? TS_IR_EXIT1 : TS_IR_SHIFT;
            TS_IR_SHIFT: return m ? TS_IR_EXIT1 : TS_IR_SHIFT;
            TS_IR_EXIT1: return m ? TS_IR_UPD   : TS_IR_PAUSE;
            TS_IR_PAUSE: return m ? TS_IR_EXIT2 : TS_IR_PAUSE;
            TS_IR_EXIT2: return m ? TS_IR_UPD   : TS_IR_SHIFT;
            default:     return m ? TS_DR_SEL   : TS_IDLE;
        endcase
    endfunction

    function automatic logic is_capture(input tap_state_e s);
        return (s == TS_DR_CAP) || (s == TS_IR_CAP);
    endfunction

    function automatic logic is_shift(input tap_state_e s);
        return (s == TS_DR_SHIFT) || (s == TS_IR_SHIFT);
    endfunction

    function automatic logic is_pause(input tap_state_e s);
        return (s == TS_DR_PAUSE) || (s == TS_IR_PAUSE);
    endfunction

    function automatic logic is_update(input tap_state_e s);
        return (s == TS_DR_UPD) || (s == TS_IR_UPD);
    endfunction

endpackage

// File: rtl/tap_watch_fsm.sv
// Tracks the controller state from mode select and test reset, measures how
// long each state lasts and flags capture, update and reset entries.
// Assumes inputs are stable around each rising edge of clk (the test clock).
module tap_watch_fsm
    import tap_watch_pkg::*;
#(
    parameter int DWELL_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trst_n,
    input  logic               tms,
    output tap_state_e         state,
    output tap_state_e         state_nxt,
    output logic [DWELL_W-1:0] dwell,
    output logic               scan_ir,
    output logic               cap_pulse,
    output logic               upd_pulse,
    output logic               rst_pulse
);

    localparam logic [DWELL_W-1:0] DWELL_MAX = {DWELL_W{1'b1}};

    // Next state: the test reset overrides the mode-select walk.
    always_comb begin
        state_nxt = trst_n ? tap_next(state, tms) : TS_RESET;
    end

    // State register and entry flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= TS_RESET;
            cap_pulse <= 1'b0;
            upd_pulse <= 1'b0;
            rst_pulse <= 1'b0;
            scan_ir   <= 1'b0;
        end else begin
            state     <= state_nxt;
            cap_pulse <= is_capture(state_nxt);
            upd_pulse <= is_update(state_nxt);
            rst_pulse <= (state_nxt == TS_RESET) && (state != TS_RESET);
            if (state_nxt == TS_IR_CAP)
                scan_ir <= 1'b1;
            else if (state_nxt == TS_DR_CAP)
                scan_ir <= 1'b0;
        end
    end

    // Saturating dwell counter, restarted on every state change.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dwell <= '0;
        else if (state_nxt != state)
            dwell <= '0;
        else if (dwell != DWELL_MAX)
            dwell <= dwell + 1'b1;
    end

    // Checker helper: run of consecutive high mode-select samples, capped at 5.
    logic [2:0] ones_run;
    always_ff @(posedge clk) begin
        if (!rst_n)
            ones_run <= '0;
        else if (!tms)
            ones_run <= '0;
        else if (ones_run != 3'd5)
            ones_run <= ones_run + 1'b1;
    end

    p_trst_forces_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !trst_n |=> state == TS_RESET);

    p_reset_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_RESET && tms) |=> state == TS_RESET);

    p_five_ones_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ones_run == 3'd5 |-> state == TS_RESET);

    p_dwell_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state != $past(state) |-> dwell == '0);

    p_capture_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |=> !cap_pulse);

endmodule

// File: rtl/tap_watch_scan.sv
// Counts shifted bits and pause cycles of a scan, collects the serial words
// LSB first and publishes a report while the controller sits in update.
// Assumes tdo was launched on the falling edge and is sampled here on the rise.
module tap_watch_scan
    import tap_watch_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int CNT_W   = 16,
    parameter int PAUSE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  tap_state_e         state,
    input  tap_state_e         state_nxt,
    input  logic               tdi,
    input  logic               tdo,
    output logic               rpt_valid,
    output logic               rpt_is_ir,
    output logic [CNT_W-1:0]   rpt_bits,
    output logic [PAUSE_W-1:0] rpt_pauses,
    output logic [WORD_W-1:0]  rpt_tdi,
    output logic [WORD_W-1:0]  rpt_tdo
);

    localparam logic [CNT_W-1:0]   BITS_MAX  = {CNT_W{1'b1}};
    localparam logic [PAUSE_W-1:0] PAUSE_MAX = {PAUSE_W{1'b1}};

    logic [CNT_W-1:0]   bit_cnt;
    logic [PAUSE_W-1:0] pause_cnt;
    logic [WORD_W-1:0]  w_tdi, w_tdo;
    logic               clr, shifting, pausing;

    // Phase decode of the current and following state.
    always_comb begin
        clr      = is_capture(state_nxt);
        shifting = is_shift(state);
        pausing  = is_pause(state);
    end

    // Bit and pause counters with saturation, cleared on capture entry.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            bit_cnt   <= '0;
            pause_cnt <= '0;
        end else begin
            if (shifting && bit_cnt != BITS_MAX)
                bit_cnt <= bit_cnt + 1'b1;
            if (pausing && pause_cnt != PAUSE_MAX)
                pause_cnt <= pause_cnt + 1'b1;
        end
    end

    // Word collection: bit k of the scan lands in position k while it fits.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            w_tdi <= '0;
            w_tdo <= '0;
        end else if (shifting) begin
            for (int i = 0; i < WORD_W; i++) begin
                if (bit_cnt == CNT_W'(i)) begin
                    w_tdi[i] <= tdi;
                    w_tdo[i] <= tdo;
                end
            end
        end
    end

    // Report register loaded on the edge that enters update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rpt_valid  <= 1'b0;
            rpt_is_ir  <= 1'b0;
            rpt_bits   <= '0;
            rpt_pauses <= '0;
            rpt_tdi    <= '0;
            rpt_tdo    <= '0;
        end else begin
            rpt_valid <= is_update(state_nxt);
            if (is_update(state_nxt)) begin
                rpt_is_ir  <= (state_nxt == TS_IR_UPD);
                rpt_bits   <= bit_cnt;
                rpt_pauses <= pause_cnt;
                rpt_tdi    <= w_tdi;
                rpt_tdo    <= w_tdo;
            end
        end
    end

    p_pause_moves_no_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        is_pause(state) |=> $stable(bit_cnt) && $stable(w_tdi) && $stable(w_tdo));

    p_cleared_in_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        is_capture(state) |-> bit_cnt == '0 && pause_cnt == '0);

    p_report_after_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |-> ($past(state) == TS_DR_EXIT1 || $past(state) == TS_DR_EXIT2 ||
                       $past(state) == TS_IR_EXIT1 || $past(state) == TS_IR_EXIT2));

    p_bits_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt == BITS_MAX && is_shift(state)) |=> bit_cnt == BITS_MAX);

endmodule

// File: rtl/tap_watch.sv
// Passive test access port monitor: state tracking plus per-scan statistics.
// Drives nothing on the observed port; clocked by the observed test clock.
module tap_watch
    import tap_watch_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int CNT_W   = 16,
    parameter int PAUSE_W = 16,
    parameter int DWELL_W = 8
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic               tdo,
    output logic [3:0]         state,
    output logic [DWELL_W-1:0] dwell,
    output logic               scan_is_ir,
    output logic               capture_pulse,
    output logic               update_pulse,
    output logic               reset_pulse,
    output logic               rpt_valid,
    output logic               rpt_is_ir,
    output logic [CNT_W-1:0]   rpt_bits,
    output logic [PAUSE_W-1:0] rpt_pauses,
    output logic [WORD_W-1:0]  rpt_tdi,
    output logic [WORD_W-1:0]  rpt_tdo
);

    tap_state_e cur_st, nxt_st;

    tap_watch_fsm #(.DWELL_W(DWELL_W)) u_fsm (
        .clk       (tck),
        .rst_n     (rst_n),
        .trst_n    (trst_n),
        .tms       (tms),
        .state     (cur_st),
        .state_nxt (nxt_st),
        .dwell     (dwell),
        .scan_ir   (scan_is_ir),
        .cap_pulse (capture_pulse),
        .upd_pulse (update_pulse),
        .rst_pulse (reset_pulse)
    );

    tap_watch_scan #(.WORD_W(WORD_W), .CNT_W(CNT_W), .PAUSE_W(PAUSE_W)) u_scan (
        .clk        (tck),
        .rst_n      (rst_n),
        .state      (cur_st),
        .state_nxt  (nxt_st),
        .tdi        (tdi),
        .tdo        (tdo),
        .rpt_valid  (rpt_valid),
        .rpt_is_ir  (rpt_is_ir),
        .rpt_bits   (rpt_bits),
        .rpt_pauses (rpt_pauses),
        .rpt_tdi    (rpt_tdi),
        .rpt_tdo    (rpt_tdo)
    );

    assign state = cur_st;

    p_update_with_report_r8: assert property (@(posedge tck) disable iff (!rst_n)
        update_pulse == rpt_valid);

endmodule

// File: tb/tap_watch_test.sv
// Scoreboard bench: the driver steps a reference controller and queues the
// expected scan reports; a monitor pops and compares them as they appear.
module tap_watch_test;

    localparam int WORD_W  = 16;
    localparam int CNT_W   = 6;
    localparam int PAUSE_W = 4;
    localparam int DWELL_W = 4;
    localparam int BITS_MAX  = (1 << CNT_W) - 1;
    localparam int PAUSE_MAX = (1 << PAUSE_W) - 1;
    localparam int DWELL_MAX = (1 << DWELL_W) - 1;

    typedef struct {
        int ir;
        int bits;
        int pauses;
        int wi;
        int wo;
    } rpt_t;

    logic tck = 1'b0, rst_n = 1'b0, trst_n = 1'b1, tms = 1'b1, tdi = 1'b0, tdo = 1'b0;
    logic [3:0]         state;
    logic [DWELL_W-1:0] dwell;
    logic               scan_is_ir, capture_pulse, update_pulse, reset_pulse;
    logic               rpt_valid, rpt_is_ir;
    logic [CNT_W-1:0]   rpt_bits;
    logic [PAUSE_W-1:0] rpt_pauses;
    logic [WORD_W-1:0]  rpt_tdi, rpt_tdo;

    tap_watch #(.WORD_W(WORD_W), .CNT_W(CNT_W), .PAUSE_W(PAUSE_W), .DWELL_W(DWELL_W)) uut (
        .tck(tck), .rst_n(rst_n), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .state(state), .dwell(dwell), .scan_is_ir(scan_is_ir),
        .capture_pulse(capture_pulse), .update_pulse(update_pulse), .reset_pulse(reset_pulse),
        .rpt_valid(rpt_valid), .rpt_is_ir(rpt_is_ir), .rpt_bits(rpt_bits),
        .rpt_pauses(rpt_pauses), .rpt_tdi(rpt_tdi), .rpt_tdo(rpt_tdo)
    );

    always #2 tck = ~tck;

    int checks = 0, fails = 0;
    rpt_t exp_q[$];

    // Reference model state.
    int m_state = 0, m_dwell = 0, m_ir = 0, m_cap = 0, m_upd = 0, m_rst = 0;
    int m_bits = 0, m_pause = 0;
    logic [WORD_W-1:0] m_wi = '0, m_wo = '0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int ref_next(input int s, input logic m);
        case (s)
            0: return m ? 0 : 1;
            1: return m ? 2 : 1;
            2: return m ? 9 : 3;
            3, 4: return m ? 5 : 4;
            5: return m ? 8 : 6;
            6: return m ? 7 : 6;
            7: return m ? 8 : 4;
            8, 15: return m ? 2 : 1;
            9: return m ? 0 : 10;
            10, 11: return m ? 12 : 11;
            12: return m ? 15 : 13;
            13: return m ? 14 : 13;
            default: return m ? 15 : 11;
        endcase
    endfunction

    // Advance the reference model by one rising edge.
    task automatic model_edge(input logic t, input logic di, input logic dout, input logic tr);
        int nxt;
        rpt_t r;
        if (!rst_n) begin
            m_state = 0; m_dwell = 0; m_ir = 0; m_cap = 0; m_upd = 0; m_rst = 0;
            m_bits = 0; m_pause = 0; m_wi = '0; m_wo = '0;
            return;
        end
        nxt = tr ? ref_next(m_state, t) : 0;
        if (m_state == 4 || m_state == 11) begin
            if (m_bits < WORD_W) begin
                m_wi[m_bits] = di;
                m_wo[m_bits] = dout;
            end
            if (m_bits != BITS_MAX) m_bits++;
        end
        if ((m_state == 6 || m_state == 13) && m_pause != PAUSE_MAX) m_pause++;
        if (nxt == 3 || nxt == 10) begin
            m_bits = 0; m_pause = 0; m_wi = '0; m_wo = '0;
        end
        if (nxt == 8 || nxt == 15) begin
            r.ir = (nxt == 15); r.bits = m_bits; r.pauses = m_pause;
            r.wi = int'(m_wi); r.wo = int'(m_wo);
            exp_q.push_back(r);
        end
        m_cap = (nxt == 3 || nxt == 10);
        m_upd = (nxt == 8 || nxt == 15);
        m_rst = (nxt == 0 && m_state != 0);
        if (nxt == 10) m_ir = 1;
        else if (nxt == 3) m_ir = 0;
        m_dwell = (nxt != m_state) ? 0 : ((m_dwell == DWELL_MAX) ? DWELL_MAX : m_dwell + 1);
        m_state = nxt;
    endtask

    // Driver: one test-clock cycle with the given inputs, then per-cycle checks.
    task automatic step(input logic t, input logic di, input logic dout, input logic tr);
        tms = t; tdi = di; tdo = dout; trst_n = tr;
        @(posedge tck);
        model_edge(t, di, dout, tr);
        @(negedge tck);
        chk("R2 state", int'(state), m_state);
        chk("R10 dwell", int'(dwell), m_dwell);
        chk("R4 capture_pulse", int'(capture_pulse), m_cap);
        chk("R4 scan_is_ir", int'(scan_is_ir), m_ir);
        chk("R8 update_pulse", int'(update_pulse), m_upd);
        chk("R8 rpt_valid", int'(rpt_valid), m_upd);
        chk("R9 reset_pulse", int'(reset_pulse), m_rst);
    endtask

    task automatic rstep(input logic t);
        step(t, 1'($urandom), 1'($urandom), 1'b1);
    endtask

    // One scan from idle: n1 bits, optional pause of plen cycles, then n2 bits.
    task automatic scan(input bit ir, input int n1, input int plen, input int n2);
        rstep(1'b1);
        if (ir) rstep(1'b1);
        rstep(1'b0);
        rstep(1'b0);
        for (int i = 0; i < n1; i++) rstep(i == n1 - 1);
        if (plen > 0) begin
            rstep(1'b0);
            for (int i = 0; i < plen; i++) rstep(i == plen - 1);
            rstep(1'b0);
            for (int i = 0; i < n2; i++) rstep(i == n2 - 1);
        end
        rstep(1'b1);
        rstep(1'b0);
    endtask

    // Monitor: compare every published report against the queued expectation.
    always @(negedge tck) begin
        if (rst_n && rpt_valid) begin
            if (exp_q.size() == 0) begin
                chk("R8 unexpected report", 1, 0);
            end else begin
                rpt_t e;
                e = exp_q.pop_front();
                chk("R8 rpt_is_ir", int'(rpt_is_ir), e.ir);
                chk("R5 R7 rpt_bits", int'(rpt_bits), e.bits);
                chk("R6 rpt_pauses", int'(rpt_pauses), e.pauses);
                chk("R5 R7 rpt_tdi", int'(rpt_tdi), e.wi);
                chk("R5 R7 rpt_tdo", int'(rpt_tdo), e.wo);
            end
        end
    end

    bit done = 0;

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R1 state under rst_n", int'(state), 0);
        chk("R1 rpt_valid under rst_n", int'(rpt_valid), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) rstep(1'b1);
        chk("R1 held in reset by tms", int'(state), 0);
        rstep(1'b0);
        chk("R1 leaves reset on 0", int'(state), 1);

        // R2 R5: plain data and instruction scans
        scan(1'b0, 8, 0, 0);
        scan(1'b1, 5, 0, 0);
        scan(1'b0, 1, 0, 0);

        // R6: pause then resume, counts kept across the pause
        scan(1'b0, 3, 4, 6);
        scan(1'b1, 2, 20, 2);

        // R7: over-length scan saturates words and count
        scan(1'b0, 70, 0, 0);

        // R10: long idle saturates dwell
        for (int i = 0; i < 20; i++) rstep(1'b0);
        chk("R10 dwell saturated", int'(dwell), DWELL_MAX);

        // R3: abort from shift by five highs
        rstep(1'b1); rstep(1'b0); rstep(1'b0); rstep(1'b0);
        for (int i = 0; i < 5; i++) rstep(1'b1);
        chk("R3 five ones reach reset", int'(state), 0);

        // R9: test reset mid-scan
        rstep(1'b0); rstep(1'b1); rstep(1'b0); rstep(1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 reset_pulse after trst", int'(reset_pulse), 1);
        chk("R1 trst forces reset", int'(state), 0);

        // Random streams with rare test resets
        for (int i = 0; i < 4000; i++)
            step(1'($urandom_range(0, 2) == 0), 1'($urandom), 1'($urandom),
                 1'($urandom_range(0, 99) != 0));

        for (int i = 0; i < 6; i++) rstep(1'b1);
        chk("R8 all reports seen", exp_q.size(), 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule